// File: doc/BRIEF.md
# Bus-Attached Serial Port with Separate Bit-Rate Clock

This block is a minimal asynchronous serial port for a simple strobe/acknowledge register bus with an 8-bit data path and a 2-bit address. Writing the data address hands one byte to the transmitter. The transmitter sends it as a frame with one start bit, eight data bits and one stop bit. The receiver watches the incoming serial line, rebuilds frames and places each good byte in a receive holding register. A status byte and two level interrupt lines tell software when the transmitter can take a new byte and when a received byte is waiting.

Bit timing does not come from the bus clock. A separate bit-rate clock input is first divided by the `DIVISOR` parameter. The result is then divided by a fixed factor of four, so one serial bit lasts four divided ticks. The bit-rate clock is treated as an asynchronous input: it is brought into the bus clock domain through a two-flop synchroniser, and its rising edges become a one-cycle enable. The whole block therefore runs from the bus clock. This requires the bus clock to be at least four times faster than the bit-rate clock.

Top module: `mini_uart`

## Requirements
- R1: After a synchronous active-low reset, the `txd` line is high, `irq_tx` is 1, `irq_rx` is 0, `bus_ack` is 0, and a read of address 1 returns 0x01.
- R2: Each strobe that the block accepts produces `bus_ack` high for exactly one bus clock, in the cycle after the strobe is sampled. No wait states are inserted.
- R3: A write to address 0 while the transmitter is free loads the byte and clears status bit 0 and `irq_tx` in the acknowledge cycle. The byte is then sent on `txd` in this order: a low start bit, data bits from bit 0 to bit 7, and a high stop bit.
- R4: Once the stop bit has lasted a full bit time, status bit 0 and `irq_tx` return to 1 and `txd` stays high.
- R5: A frame received on `rxd` with a high stop bit sets status bit 1 and `irq_rx`. A read of address 0 then returns the byte, with the first bit received as bit 0. With the transmitter idle, the status then reads 0x03.
- R6: A read of address 0 clears status bit 1 and `irq_rx`.
- R7: If a second byte arrives before address 0 is read, it replaces the first one in the holding register.
- R8: A low pulse on `rxd` that is high again one tick after it was detected is treated as a false start. No byte is delivered.
- R9: A frame whose stop bit is sampled low is discarded: the flag stays clear and the holding register keeps its old value. The receiver waits for `rxd` to go high again before it looks for the next start bit.
- R10: One serial bit lasts 4 × `DIVISOR` rising edges of `baud_clk`. A divisor of 0 acts as 1.
- R11: Writes to addresses 1 to 3 have no effect, and reads of addresses 2 and 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked by it |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 is data, 1 is status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_ack` is high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_stb | input | 1 | Access request |
| bus_ack | output | 1 | One-cycle completion pulse |
| irq_tx | output | 1 | High while the transmitter can take a byte |
| irq_rx | output | 1 | High while a received byte is unread |
| baud_clk | input | 1 | Bit-rate reference clock, asynchronous to `clk` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The byte patterns used for both directions are 0x32, 0xA5, 0x00, 0xFF, 0x81 and 0x5E. All-zero and all-one data separate the start and stop bits from the data bits. The alternating and single-end-bit patterns expose a reversed bit order or a one-bit shift. For patterns whose bit 0 is 1, the bench times the exact cycle at which the start bit ends, which shows whether the divisor and the factor of four are applied. Directed cases cover back-to-back receives without a read, a short glitch, a low stop bit followed by a good frame, and accesses to unused addresses. Together these separate overwrite, false-start, framing-error and decode faults.

// File: rtl/mini_uart_pkg.sv
// Shared constants for the serial port: bus widths, register addresses,
// status bit positions and receiver state encoding.
package mini_uart_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int OVS     = 4;                  // divided ticks per serial bit
    localparam int PHASE_W = $clog2(OVS);
    localparam int FRAME_W = DATA_W + 2;         // start + data + stop

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

    localparam int ST_TX_FREE = 0;
    localparam int ST_RX_FULL = 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;
endpackage

// File: rtl/mini_uart_tick.sv
// Bit-rate tick generator.
// Brings the asynchronous baud_clk into the clk domain, finds its rising
// edges and emits a one-cycle tick on every DIVISOR-th edge (0 acts as 1).
// Assumes clk runs at least four times faster than baud_clk.
module mini_uart_tick #(
    parameter int DIVISOR = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_clk,
    output logic tick
);
    localparam int DIV_EFF = (DIVISOR < 1) ? 1 : DIVISOR;
    localparam int CNT_W   = (DIV_EFF > 1) ? $clog2(DIV_EFF) : 1;

    logic [2:0]       bsync;   // [0],[1] synchroniser, [2] previous value
    logic             rise;
    logic [CNT_W-1:0] cnt;

    // Purpose: two-flop synchroniser plus one history flop for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) bsync <= '0;
        else        bsync <= {bsync[1:0], baud_clk};
    end

    assign rise = bsync[1] & ~bsync[2];

    // Purpose: count synchronised edges and pulse tick at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (rise) begin
                if (cnt == CNT_W'(DIV_EFF - 1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_tick_from_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(rise));
endmodule

// File: rtl/mini_uart_tx.sv
// Serial transmitter.
// A load while idle arms the transmitter. The frame starts on the next tick,
// so every bit, the start bit included, lasts exactly OVS ticks.
// A load while armed or busy is ignored; the top only loads when idle.
module mini_uart_tx
    import mini_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              idle
);
    logic               armed;
    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [PHASE_W-1:0] phase;
    logic [3:0]         bitn;

    // Purpose: capture the byte, then shift one frame bit out every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            busy  <= 1'b0;
            shreg <= '1;
            phase <= '0;
            bitn  <= '0;
        end else begin
            if (load && !armed && !busy) begin
                armed <= 1'b1;
                shreg <= {1'b1, data, 1'b0};
            end
            if (tick) begin
                if (armed) begin
                    armed <= 1'b0;
                    busy  <= 1'b1;
                    phase <= '0;
                    bitn  <= '0;
                end else if (busy) begin
                    if (phase == PHASE_W'(OVS - 1)) begin
                        phase <= '0;
                        shreg <= {1'b1, shreg[FRAME_W-1:1]};
                        if (bitn == 4'(FRAME_W - 1)) busy <= 1'b0;
                        else                         bitn <= bitn + 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
            end
        end
    end

    assign txd  = busy ? shreg[0] : 1'b1;
    assign idle = !armed && !busy;

    p_line_moves_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(txd));
    p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> txd);
endmodule

// File: rtl/mini_uart_rx.sv
// Serial receiver.
// Samples the synchronised line on each tick. A low sample starts a frame,
// which is confirmed one tick later. Each later bit is sampled OVS ticks after
// the previous one. A high stop bit delivers the byte through a one-cycle
// valid pulse. A low stop bit discards the byte and waits for the line to
// return high.
module mini_uart_rx
    import mini_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    logic [1:0]         rsync;
    logic               rxs;
    rx_state_t          state;
    logic [PHASE_W-1:0] phase;
    logic [2:0]         bitn;

    // Purpose: two-flop synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) rsync <= '1;
        else        rsync <= {rsync[0], rxd};
    end

    assign rxs = rsync[1];

    // Purpose: frame state machine, run once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            phase <= '0;
            bitn  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxs) begin
                            state <= RX_START;
                            phase <= '0;
                        end
                    end
                    RX_START: begin
                        if (rxs) begin
                            state <= RX_IDLE;
                        end else begin
                            state <= RX_DATA;
                            phase <= '0;
                            bitn  <= '0;
                        end
                    end
                    RX_DATA: begin
                        if (phase == PHASE_W'(OVS - 1)) begin
                            phase <= '0;
                            data  <= {rxs, data[DATA_W-1:1]};
                            if (bitn == 3'(DATA_W - 1)) state <= RX_STOP;
                            else                        bitn  <= bitn + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (phase == PHASE_W'(OVS - 1)) begin
                            phase <= '0;
                            if (rxs) begin
                                valid <= 1'b1;
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_HOLD;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: begin
                        if (rxs) state <= RX_IDLE;
                    end
                endcase
            end
        end
    end

    p_deliver_on_high_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(rxs) && $past(tick)));
    p_single_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/mini_uart.sv
// Serial port top: bus registers, status flags and interrupt lines.
// Address 0 reads the receive holding register and writes the transmitter.
// Address 1 reads status: bit 0 means the transmitter is free, bit 1 means
// a byte is waiting. Accesses are acknowledged one cycle after the strobe.
module mini_uart
    import mini_uart_pkg::*;
#(
    parameter int DIVISOR = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    output logic              bus_ack,
    output logic              irq_tx,
    output logic              irq_rx,
    input  logic              baud_clk,
    output logic              txd,
    input  logic              rxd
);
    logic              tick;
    logic              tx_idle;
    logic              tx_load;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rx_hold;
    logic              rx_full;
    logic              accept;
    logic              rd_data;
    logic [DATA_W-1:0] status;

    mini_uart_tick #(.DIVISOR(DIVISOR)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_clk (baud_clk),
        .tick     (tick)
    );

    mini_uart_tx u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tx_load),
        .data  (bus_wdata),
        .txd   (txd),
        .idle  (tx_idle)
    );

    mini_uart_rx u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (rxd),
        .valid (rx_valid),
        .data  (rx_byte)
    );

    assign accept  = bus_stb && !bus_ack;
    assign tx_load = accept && bus_we && (bus_addr == ADDR_DATA) && tx_idle;
    assign rd_data = accept && !bus_we && (bus_addr == ADDR_DATA);

    // Purpose: assemble the status byte from the two flags.
    always_comb begin
        status             = '0;
        status[ST_TX_FREE] = tx_idle;
        status[ST_RX_FULL] = rx_full;
    end

    // Purpose: acknowledge and register read data for each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= accept;
            if (accept && !bus_we) begin
                case (bus_addr)
                    ADDR_DATA: bus_rdata <= rx_hold;
                    ADDR_STAT: bus_rdata <= status;
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end

    // Purpose: receive holding register and its flag; a new byte wins a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
        end else if (rx_valid) begin
            rx_hold <= rx_byte;
            rx_full <= 1'b1;
        end else if (rd_data) begin
            rx_full <= 1'b0;
        end
    end

    assign irq_tx = tx_idle;
    assign irq_rx = rx_full;

    p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_ack_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_stb));
    p_write_takes_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_we && bus_addr == ADDR_DATA && irq_tx) |=> !irq_tx);
    p_read_clears_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !irq_rx);
endmodule

// File: tb/mini_uart_bench.sv
`timescale 1ns/1ps
module mini_uart_bench;
    localparam int DIV     = 2;
    localparam int BIT_CYC = 4 * DIV * 8;   // baud_clk period is 8 bus clocks

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       bus_we;
    logic       bus_stb;
    logic       bus_ack;
    logic       irq_tx;
    logic       irq_rx;
    logic       baud_clk = 1'b0;
    logic       txd;
    logic       rxd;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam logic [7:0] VEC [0:5] = '{8'h32, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h5E};

    mini_uart #(.DIVISOR(DIV)) u_mini_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_stb(bus_stb),
        .bus_ack(bus_ack), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .baud_clk(baud_clk), .txd(txd), .rxd(rxd)
    );

    always #2.5 clk = ~clk;
    always #20 baud_clk = ~baud_clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic bus_access(input logic we, input logic [1:0] a,
                              input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; bus_stb = 1'b1;
        for (int g = 0; g < 10; g++) begin
            @(negedge clk);
            if (bus_ack) break;
        end
        rd = bus_rdata;
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] rd);
        bus_access(1'b0, a, 8'h00, rd);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] wd);
        logic [7:0] dummy;
        bus_access(1'b1, a, wd, dummy);
    endtask

    // Decode one frame from txd; also report the line just before and after
    // the first bit boundary.
    task automatic tx_capture(output logic [7:0] b, output logic stop_b,
                              output logic before_edge, output logic after_edge);
        int t0;
        int guard = 0;
        while (txd === 1'b1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        t0 = cyc;
        wait_until(t0 + BIT_CYC / 2);
        check("R3 start bit low", 32'(txd), 32'h0);
        wait_until(t0 + BIT_CYC - 1);
        before_edge = txd;
        wait_until(t0 + BIT_CYC);
        after_edge = txd;
        for (int k = 0; k < 8; k++) begin
            wait_until(t0 + BIT_CYC / 2 + (k + 1) * BIT_CYC);
            b[k] = txd;
        end
        wait_until(t0 + BIT_CYC / 2 + 9 * BIT_CYC);
        stop_b = txd;
        wait_until(t0 + 10 * BIT_CYC + 4);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stop_v);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..all: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] got;
        logic       stp;
        logic       be;
        logic       ae;
        logic       tx_stayed_high;

        rst_n = 1'b0; rxd = 1'b1; bus_stb = 1'b0; bus_we = 1'b0;
        bus_addr = 2'd0; bus_wdata = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 txd", 32'(txd), 32'h1);
        check("R1 irq_tx", 32'(irq_tx), 32'h1);
        check("R1 irq_rx", 32'(irq_rx), 32'h0);
        check("R1 ack", 32'(bus_ack), 32'h0);
        bus_rd(2'd1, rd);
        check("R1 status", 32'(rd), 32'h01);

        // R2: one-cycle acknowledge
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd1; bus_stb = 1'b1;
        check("R2 no ack in strobe cycle", 32'(bus_ack), 32'h0);
        @(negedge clk);
        check("R2 ack next cycle", 32'(bus_ack), 32'h1);
        bus_stb = 1'b0;
        @(negedge clk);
        check("R2 ack one cycle only", 32'(bus_ack), 32'h0);

        // Vector table: transmit and receive each pattern.
        for (int i = 0; i < 6; i++) begin
            bus_wr(2'd0, VEC[i]);
            check("R3 irq_tx cleared by load", 32'(irq_tx), 32'h0);
            tx_capture(got, stp, be, ae);
            check("R3 tx data", 32'(got), 32'(VEC[i]));
            check("R3 stop bit high", 32'(stp), 32'h1);
            if (VEC[i][0]) begin
                check("R10 start bit still low at last cycle", 32'(be), 32'h0);
                check("R10 bit0 begins after 4*DIV baud edges", 32'(ae), 32'h1);
            end
            check("R4 irq_tx back", 32'(irq_tx), 32'h1);
            check("R4 txd idle high", 32'(txd), 32'h1);

            rx_send(VEC[i], 1'b1);
            check("R5 irq_rx set", 32'(irq_rx), 32'h1);
            bus_rd(2'd1, rd);
            check("R5 status 0x03", 32'(rd), 32'h03);
            bus_rd(2'd0, rd);
            check("R5 rx data", 32'(rd), 32'(VEC[i]));
            @(negedge clk);
            check("R6 irq_rx cleared", 32'(irq_rx), 32'h0);
            bus_rd(2'd1, rd);
            check("R6 status after read", 32'(rd), 32'h01);
        end

        // R7: overwrite of an unread byte
        rx_send(8'h11, 1'b1);
        rx_send(8'h22, 1'b1);
        bus_rd(2'd1, rd);
        check("R7 status still 0x03", 32'(rd), 32'h03);
        bus_rd(2'd0, rd);
        check("R7 newest byte kept", 32'(rd), 32'h22);

        // R8: short glitch is a false start
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CYC) @(negedge clk);
        check("R8 no byte from glitch", 32'(irq_rx), 32'h0);
        bus_rd(2'd1, rd);
        check("R8 status", 32'(rd), 32'h01);

        // R9: low stop bit discards the byte; the next frame is received.
        rx_send(8'h5C, 1'b0);
        repeat (2 * BIT_CYC) @(negedge clk);
        check("R9 no flag on framing error", 32'(irq_rx), 32'h0);
        bus_rd(2'd0, rd);
        check("R9 holding register unchanged", 32'(rd), 32'h22);
        rx_send(8'h6D, 1'b1);
        check("R9 recovery flag", 32'(irq_rx), 32'h1);
        bus_rd(2'd0, rd);
        check("R9 recovery data", 32'(rd), 32'h6D);

        // R11: unused addresses
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h55);
        bus_wr(2'd3, 8'hAA);
        tx_stayed_high = 1'b1;
        for (int c = 0; c < 3 * BIT_CYC; c++) begin
            @(negedge clk);
            if (txd !== 1'b1) tx_stayed_high = 1'b0;
        end
        check("R11 no frame from other addresses", 32'(tx_stayed_high), 32'h1);
        check("R11 irq_tx unchanged", 32'(irq_tx), 32'h1);
        bus_rd(2'd1, rd);
        check("R11 status unchanged", 32'(rd), 32'h01);
        bus_rd(2'd2, rd);
        check("R11 read addr 2", 32'(rd), 32'h00);
        bus_rd(2'd3, rd);
        check("R11 read addr 3", 32'(rd), 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule